// File: doc/BRIEF.md
# DDS Register Write Decoder

This block sits between a parallel configuration port and the synthesis datapath of a direct digital synthesizer. Each 16-bit word arrives with a one-cycle valid strobe. The two top bits of the word pick the destination, and the rest of the word carries the payload. The destination is either the control register, one of two 28-bit frequency tuning registers, or one of two 12-bit phase offset registers. The decoder keeps all of these registers and presents their current contents, together with the decoded control flags, to the waveform logic downstream.

A frequency register can be loaded in one of two ways. In full-load mode, two writes to the same register deliver a complete 28-bit value: the first write carries the low half and the second carries the high half. The register takes the whole new value at once when the second write arrives, so the datapath never sees a mix of old and new halves. In half-load mode, each write replaces one 14-bit half of the register, and a control flag chooses which half. A pending full-load sequence is dropped if any control write or phase write arrives before its second half.

Top module: `dds_cfg_decoder`

## Requirements
- R1: Bits 15:14 of a word select its target. The encoding is 00 for the control register, 01 for frequency register 0, 10 for frequency register 1 and 11 for a phase register. A write changes only its target.
- R2: A control write loads the flag outputs from these word bits: full_load_mode from bit 13, half_hi_sel from 12, freq_sel from 11, phase_sel from 10, core_reset from 8, clk_sleep from 7, dac_sleep from 6, bit_out_en from 5, bit_div2 from 3 and tri_wave from 1. Bits 9, 4, 2 and 0 are ignored. Every register output changes on the clock edge that samples the strobe.
- R3: A phase write uses word bit 13 to select phase register 0 (value 0) or phase register 1 (value 1). It loads word bits 11:0 into the selected register. Bit 12 is ignored, and the other phase register is left unchanged.
- R4: When full_load_mode is 1, the first write to a frequency register holds word bits 13:0 as the pending low half. The frequency outputs do not change on that write.
- R5: The next frequency write to the same register, with only idle cycles in between, completes the sequence. It loads the register with its own bits 13:0 as bits 27:14 and the held half as bits 13:0, both on the same edge.
- R6: When a sequence is pending and a frequency write targets the other register, that write starts a new sequence for the other register. Neither register changes on that write.
- R7: When full_load_mode is 0, a frequency write replaces bits 27:14 of its register with word bits 13:0 if half_hi_sel is 1, or bits 13:0 if half_hi_sel is 0. The other half is kept.
- R8: When full_load_mode is 1, half_hi_sel has no effect on frequency writes.
- R9: A control write or a phase write discards a pending sequence, so the next frequency write is a first write.
- R10: While wr_valid is 0, no output changes, whatever value wr_word holds.
- R11: A synchronous active-high rst clears all registers, all flags and any pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe marking wr_word as a write |
| wr_word | input | 16 | Configuration word |
| freq0_word | output | 28 | Frequency register 0 |
| freq1_word | output | 28 | Frequency register 1 |
| phase0_word | output | 12 | Phase register 0 |
| phase1_word | output | 12 | Phase register 1 |
| full_load_mode | output | 1 | Two-write full frequency load enabled |
| half_hi_sel | output | 1 | Half-load targets the high half |
| freq_sel | output | 1 | Frequency register choice for the datapath |
| phase_sel | output | 1 | Phase register choice for the datapath |
| core_reset | output | 1 | Datapath reset request |
| clk_sleep | output | 1 | Datapath clock stop request |
| dac_sleep | output | 1 | Converter power-down request |
| bit_out_en | output | 1 | Route a square-wave bit to the output |
| bit_div2 | output | 1 | Square-wave bit choice |
| tri_wave | output | 1 | Triangle instead of sine |

## Verification
The bench aims at the sequencing corners of full-load mode, where a faulty design would most often show a torn value:
- A register that updates on the first write would expose a half-updated word.
- Swapped halves would put the held half in bits 27:14.
- A sequence that survives an intervening control or phase write, or a switch of target register, would complete with a stale low half.
- A sequence that survives a reset would do the same.

In half-load mode it checks that the unselected half is kept, and that the half-select flag has no effect once full-load mode is on. It also writes control words with the undefined bits set, drives a phase word with bit 12 set, and changes wr_word with no strobe. A decoder that leaked any of these into its outputs would show a wrong flag, a wrong phase value or a moving register.

// File: rtl/dds_cfg_pkg.sv
package dds_cfg_pkg;

    localparam int WORD_W    = 16;
    localparam int HALF_W    = 14;
    localparam int FREQ_W    = 2 * HALF_W;
    localparam int PHASE_W   = 12;
    localparam int NUM_FREQ  = 2;
    localparam int NUM_PHASE = 2;
    localparam int FIDX_W    = $clog2(NUM_FREQ);
    localparam int PIDX_W    = $clog2(NUM_PHASE);

    // Control word bit positions
    localparam int CB_FULL  = 13;
    localparam int CB_HALF  = 12;
    localparam int CB_FSEL  = 11;
    localparam int CB_PSEL  = 10;
    localparam int CB_CRST  = 8;
    localparam int CB_CSLP  = 7;
    localparam int CB_DSLP  = 6;
    localparam int CB_BOUT  = 5;
    localparam int CB_DIV2  = 3;
    localparam int CB_TRI   = 1;
    localparam int PH_SEL_BIT = 13;

    typedef enum logic [1:0] {
        TGT_CTRL  = 2'b00,
        TGT_FREQ0 = 2'b01,
        TGT_FREQ1 = 2'b10,
        TGT_PHASE = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        FW_LO,
        FW_HI,
        FW_FULL
    } fwr_e;

    typedef struct packed {
        logic full_load;
        logic half_hi;
        logic fsel;
        logic psel;
        logic core_rst;
        logic clk_sleep;
        logic dac_sleep;
        logic bit_out;
        logic div2;
        logic tri_wave;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.full_load = w[CB_FULL];
        c.half_hi   = w[CB_HALF];
        c.fsel      = w[CB_FSEL];
        c.psel      = w[CB_PSEL];
        c.core_rst  = w[CB_CRST];
        c.clk_sleep = w[CB_CSLP];
        c.dac_sleep = w[CB_DSLP];
        c.bit_out   = w[CB_BOUT];
        c.div2      = w[CB_DIV2];
        c.tri_wave  = w[CB_TRI];
        return c;
    endfunction

endpackage

// File: rtl/dds_word_decode.sv
module dds_word_decode
    import dds_cfg_pkg::*;
(
    input  logic                wr_valid,
    input  logic [WORD_W-1:0]   wr_word,
    output logic                is_ctrl,
    output logic                is_freq,
    output logic                is_phase,
    output logic [FIDX_W-1:0]   freq_idx,
    output logic [PIDX_W-1:0]   phase_idx,
    output logic [HALF_W-1:0]   half_data,
    output logic [PHASE_W-1:0]  phase_data,
    output ctrl_t               ctrl_new
);
    tgt_e tgt;

    always_comb begin
        tgt        = tgt_e'(wr_word[WORD_W-1 -: 2]);
        is_ctrl    = wr_valid && (tgt == TGT_CTRL);
        is_phase   = wr_valid && (tgt == TGT_PHASE);
        is_freq    = wr_valid && ((tgt == TGT_FREQ0) || (tgt == TGT_FREQ1));
        freq_idx   = (tgt == TGT_FREQ1);
        phase_idx  = wr_word[PH_SEL_BIT];
        half_data  = wr_word[HALF_W-1:0];
        phase_data = wr_word[PHASE_W-1:0];
        ctrl_new   = unpack_ctrl(wr_word);
    end
endmodule

// File: rtl/dds_freq_seq.sv
module dds_freq_seq
    import dds_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                is_freq,
    input  logic [FIDX_W-1:0]   freq_idx,
    input  logic                cancel,
    input  logic                full_mode,
    input  logic                half_hi,
    input  logic [HALF_W-1:0]   half_data,
    output logic [NUM_FREQ-1:0] wr_en,
    output fwr_e                wr_kind,
    output logic [FREQ_W-1:0]   wr_data,
    output logic                pending
);
    logic [FIDX_W-1:0] pend_idx;
    logic [HALF_W-1:0] low_hold;
    logic              complete;

    always_comb begin
        complete = is_freq && full_mode && pending && (pend_idx == freq_idx);
        wr_en    = '0;
        wr_kind  = FW_LO;
        wr_data  = {half_data, half_data};
        if (is_freq) begin
            if (full_mode) begin
                if (complete) begin
                    wr_en[freq_idx] = 1'b1;
                    wr_kind         = FW_FULL;
                    wr_data         = {half_data, low_hold};
                end
            end else begin
                wr_en[freq_idx] = 1'b1;
                wr_kind         = half_hi ? FW_HI : FW_LO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            pend_idx <= '0;
            low_hold <= '0;
        end else if (is_freq && full_mode) begin
            if (complete) begin
                pending <= 1'b0;
            end else begin
                pending  <= 1'b1;
                pend_idx <= freq_idx;
                low_hold <= half_data;
            end
        end else if (is_freq || cancel) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dds_freq_reg.sv
module dds_freq_reg
    import dds_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  fwr_e              wr_kind,
    input  logic [FREQ_W-1:0] wr_data,
    output logic [FREQ_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                FW_LO:   value[HALF_W-1:0]      <= wr_data[HALF_W-1:0];
                FW_HI:   value[FREQ_W-1:HALF_W] <= wr_data[FREQ_W-1:HALF_W];
                default: value                  <= wr_data;
            endcase
        end
    end
endmodule

// File: rtl/dds_cfg_decoder.sv
module dds_cfg_decoder
    import dds_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [WORD_W-1:0]  wr_word,
    output logic [FREQ_W-1:0]  freq0_word,
    output logic [FREQ_W-1:0]  freq1_word,
    output logic [PHASE_W-1:0] phase0_word,
    output logic [PHASE_W-1:0] phase1_word,
    output logic               full_load_mode,
    output logic               half_hi_sel,
    output logic               freq_sel,
    output logic               phase_sel,
    output logic               core_reset,
    output logic               clk_sleep,
    output logic               dac_sleep,
    output logic               bit_out_en,
    output logic               bit_div2,
    output logic               tri_wave
);
    logic                is_ctrl, is_freq, is_phase;
    logic [FIDX_W-1:0]   freq_idx;
    logic [PIDX_W-1:0]   phase_idx;
    logic [HALF_W-1:0]   half_data;
    logic [PHASE_W-1:0]  phase_data;
    ctrl_t               ctrl_new, ctrl_q;
    logic [NUM_FREQ-1:0] f_wr_en;
    fwr_e                f_wr_kind;
    logic [FREQ_W-1:0]   f_wr_data;
    logic                seq_pending;
    logic [FREQ_W-1:0]   freq_q  [NUM_FREQ];
    logic [PHASE_W-1:0]  phase_q [NUM_PHASE];

    dds_word_decode dec_i (
        .wr_valid   (wr_valid),
        .wr_word    (wr_word),
        .is_ctrl    (is_ctrl),
        .is_freq    (is_freq),
        .is_phase   (is_phase),
        .freq_idx   (freq_idx),
        .phase_idx  (phase_idx),
        .half_data  (half_data),
        .phase_data (phase_data),
        .ctrl_new   (ctrl_new)
    );

    dds_freq_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .is_freq   (is_freq),
        .freq_idx  (freq_idx),
        .cancel    (is_ctrl || is_phase),
        .full_mode (ctrl_q.full_load),
        .half_hi   (ctrl_q.half_hi),
        .half_data (half_data),
        .wr_en     (f_wr_en),
        .wr_kind   (f_wr_kind),
        .wr_data   (f_wr_data),
        .pending   (seq_pending)
    );

    for (genvar g = 0; g < NUM_FREQ; g++) begin : g_freq
        dds_freq_reg freg_i (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (f_wr_en[g]),
            .wr_kind (f_wr_kind),
            .wr_data (f_wr_data),
            .value   (freq_q[g])
        );
    end

    for (genvar g = 0; g < NUM_PHASE; g++) begin : g_phase
        always_ff @(posedge clk) begin
            if (rst) begin
                phase_q[g] <= '0;
            end else if (is_phase && (phase_idx == PIDX_W'(g))) begin
                phase_q[g] <= phase_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (is_ctrl) begin
            ctrl_q <= ctrl_new;
        end
    end

    assign freq0_word     = freq_q[0];
    assign freq1_word     = freq_q[1];
    assign phase0_word    = phase_q[0];
    assign phase1_word    = phase_q[1];
    assign full_load_mode = ctrl_q.full_load;
    assign half_hi_sel    = ctrl_q.half_hi;
    assign freq_sel       = ctrl_q.fsel;
    assign phase_sel      = ctrl_q.psel;
    assign core_reset     = ctrl_q.core_rst;
    assign clk_sleep      = ctrl_q.clk_sleep;
    assign dac_sleep      = ctrl_q.dac_sleep;
    assign bit_out_en     = ctrl_q.bit_out;
    assign bit_div2       = ctrl_q.div2;
    assign tri_wave       = ctrl_q.tri_wave;
endmodule

// File: rtl/dds_cfg_decoder_chk.sv
module dds_cfg_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic [15:0] wr_word,
    input logic [27:0] freq0_word,
    input logic [27:0] freq1_word,
    input logic [11:0] phase0_word,
    input logic [11:0] phase1_word,
    input logic        full_load_mode,
    input logic        half_hi_sel,
    input logic        tri_wave,
    input logic        seq_pending
);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(freq0_word) && $stable(freq1_word) &&
                       $stable(phase0_word) && $stable(phase1_word) &&
                       $stable(full_load_mode) && $stable(half_hi_sel)));

    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_word[15:14] == 2'b00) |=>
            (full_load_mode == $past(wr_word[13]) && half_hi_sel == $past(wr_word[12]) &&
             tri_wave == $past(wr_word[1])));

    a_r3_phase0_load: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_word[15:14] == 2'b11 && !wr_word[13]) |=>
            (phase0_word == $past(wr_word[11:0]) && $stable(phase1_word)));

    a_r4_first_write_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_word[15:14] == 2'b01 && full_load_mode && !seq_pending) |=>
            ($stable(freq0_word) && $stable(freq1_word) && seq_pending));

    a_r7_high_half: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_word[15:14] == 2'b01 && !full_load_mode && half_hi_sel) |=>
            (freq0_word[27:14] == $past(wr_word[13:0]) && $stable(freq0_word[13:0])));

    a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (wr_word[15:14] == 2'b00 || wr_word[15:14] == 2'b11)) |=> !seq_pending);

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (freq0_word == '0 && freq1_word == '0 && phase0_word == '0 &&
                 phase1_word == '0 && !full_load_mode && !seq_pending));
endmodule

bind dds_cfg_decoder dds_cfg_decoder_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .wr_valid       (wr_valid),
    .wr_word        (wr_word),
    .freq0_word     (freq0_word),
    .freq1_word     (freq1_word),
    .phase0_word    (phase0_word),
    .phase1_word    (phase1_word),
    .full_load_mode (full_load_mode),
    .half_hi_sel    (half_hi_sel),
    .tri_wave       (tri_wave),
    .seq_pending    (seq_pending)
);

// File: tb/dds_cfg_decoder_tb_top.sv
`timescale 1ns/1ps
module dds_cfg_decoder_tb_top;
    localparam time CLK_PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_word = '0;
    logic [27:0] freq0_word, freq1_word;
    logic [11:0] phase0_word, phase1_word;
    logic        full_load_mode, half_hi_sel, freq_sel, phase_sel, core_reset;
    logic        clk_sleep, dac_sleep, bit_out_en, bit_div2, tri_wave;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R11";

    // Reference model state
    logic [27:0] mf [2];
    logic [11:0] mp [2];
    logic [15:0] mc;
    bit          mpend;
    int          midx;
    logic [13:0] mlow;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_cfg_decoder dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .freq0_word(freq0_word), .freq1_word(freq1_word),
        .phase0_word(phase0_word), .phase1_word(phase1_word),
        .full_load_mode(full_load_mode), .half_hi_sel(half_hi_sel),
        .freq_sel(freq_sel), .phase_sel(phase_sel), .core_reset(core_reset),
        .clk_sleep(clk_sleep), .dac_sleep(dac_sleep), .bit_out_en(bit_out_en),
        .bit_div2(bit_div2), .tri_wave(tri_wave)
    );

    always @(posedge clk) begin
        if (rst) begin
            mf[0] = '0; mf[1] = '0; mp[0] = '0; mp[1] = '0;
            mc = '0; mpend = 0; midx = 0; mlow = '0;
        end else if (wr_valid) begin
            case (wr_word[15:14])
                2'b00: begin mc = wr_word; mpend = 0; end
                2'b11: begin mp[wr_word[13]] = wr_word[11:0]; mpend = 0; end
                default: begin
                    int idx;
                    idx = wr_word[15] ? 1 : 0;
                    if (mc[13]) begin
                        if (mpend && midx == idx) begin
                            mf[idx] = {wr_word[13:0], mlow};
                            mpend = 0;
                        end else begin
                            mpend = 1; midx = idx; mlow = wr_word[13:0];
                        end
                    end else if (mc[12]) begin
                        mf[idx][27:14] = wr_word[13:0];
                    end else begin
                        mf[idx][13:0] = wr_word[13:0];
                    end
                end
            endcase
        end
    end

    function automatic logic [9:0] model_flags();
        return {mc[13], mc[12], mc[11], mc[10], mc[8], mc[7], mc[6], mc[5], mc[3], mc[1]};
    endfunction

    function automatic logic [9:0] dut_flags();
        return {full_load_mode, half_hi_sel, freq_sel, phase_sel, core_reset,
                clk_sleep, dac_sleep, bit_out_en, bit_div2, tri_wave};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [27:0] act, input logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk(cur_tag, "model freq0", freq0_word, mf[0]);
        chk(cur_tag, "model freq1", freq1_word, mf[1]);
        chk(cur_tag, "model phase0", {16'b0, phase0_word}, {16'b0, mp[0]});
        chk(cur_tag, "model phase1", {16'b0, phase1_word}, {16'b0, mp[1]});
        chk(cur_tag, "model flags", {18'b0, dut_flags()}, {18'b0, model_flags()});
    end

    task automatic wr(input logic [15:0] w);
        wr_valid = 1'b1;
        wr_word  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [27:0] prev;
        logic [15:0] lfsr;
        @(negedge clk); @(negedge clk);
        cur_tag = "R11";
        chk("R11", "reset freq0", freq0_word, 28'h0);
        chk("R11", "reset freq1", freq1_word, 28'h0);
        chk("R11", "reset phase", {4'b0, phase0_word, phase1_word}, 28'h0);
        chk("R11", "reset flags", {18'b0, dut_flags()}, 28'h0);
        rst = 1'b0;

        // Half-load mode, low then high half
        cur_tag = "R7";
        wr(16'h0000);
        wr(16'h4000 | 16'h1555);
        chk("R7", "low half freq0", freq0_word, 28'h0001555);
        chk("R1", "freq1 untouched", freq1_word, 28'h0);
        wr(16'h1000);
        wr(16'h8000 | 16'h2AAA);
        chk("R7", "high half freq1", freq1_word, {14'h2AAA, 14'h0});
        wr(16'h4000 | 16'h3FFF);
        chk("R7", "high half freq0 keeps low", freq0_word, {14'h3FFF, 14'h1555});

        // Full-load sequence
        cur_tag = "R5";
        wr(16'h2000);
        wr(16'h4000 | 16'h1234);
        chk("R4", "first write holds freq0", freq0_word, {14'h3FFF, 14'h1555});
        wr(16'h4000 | 16'h0ABC);
        chk("R5", "full load freq0", freq0_word, {14'h0ABC, 14'h1234});

        // Target switch restarts
        cur_tag = "R6";
        wr(16'h4000 | 16'h0111);
        wr(16'h8000 | 16'h0222);
        chk("R6", "switch keeps freq0", freq0_word, {14'h0ABC, 14'h1234});
        chk("R6", "switch keeps freq1", freq1_word, {14'h2AAA, 14'h0});
        wr(16'h8000 | 16'h0333);
        chk("R6", "restarted load freq1", freq1_word, {14'h0333, 14'h0222});

        // Half select ignored in full-load mode
        cur_tag = "R8";
        wr(16'h3000);
        wr(16'h4000 | 16'h0001);
        chk("R8", "hi-sel ignored first write", freq0_word, {14'h0ABC, 14'h1234});
        wr(16'h4000 | 16'h0002);
        chk("R8", "hi-sel ignored full load", freq0_word, {14'h0002, 14'h0001});

        // Phase write cancels
        cur_tag = "R9";
        wr(16'h8000 | 16'h0555);
        wr(16'hC000 | 16'h0ABC);
        chk("R3", "phase0 load", {16'b0, phase0_word}, 28'hABC);
        chk("R3", "phase1 untouched", {16'b0, phase1_word}, 28'h0);
        wr(16'h8000 | 16'h0666);
        chk("R9", "phase cancel first write", freq1_word, {14'h0333, 14'h0222});
        wr(16'h8000 | 16'h0777);
        chk("R9", "phase cancel full load", freq1_word, {14'h0777, 14'h0666});

        // Control write cancels
        wr(16'h4000 | 16'h0010);
        wr(16'h2000);
        wr(16'h4000 | 16'h0020);
        chk("R9", "ctrl cancel first write", freq0_word, {14'h0002, 14'h0001});
        wr(16'h4000 | 16'h0030);
        chk("R9", "ctrl cancel full load", freq0_word, {14'h0030, 14'h0020});

        // Phase select and ignored bit 12
        cur_tag = "R3";
        wr(16'hE000 | 16'h0FED);
        chk("R3", "phase1 load", {16'b0, phase1_word}, 28'hFED);
        chk("R3", "phase0 kept", {16'b0, phase0_word}, 28'hABC);
        wr(16'hD123);
        chk("R3", "bit12 ignored", {16'b0, phase0_word}, 28'h123);

        // Control flag positions
        cur_tag = "R2";
        wr(16'h3DEA);
        chk("R2", "all flags set", {18'b0, dut_flags()}, 28'h3FF);
        wr(16'h0215);
        chk("R2", "undefined bits ignored", {18'b0, dut_flags()}, 28'h0);
        wr(16'h0822);
        chk("R2", "fsel bit_out tri", {18'b0, dut_flags()}, 28'h085);

        // No strobe
        cur_tag = "R10";
        prev = freq0_word;
        wr_word = 16'h4FFF;
        repeat (3) @(negedge clk);
        wr_word = 16'h0000;
        repeat (2) @(negedge clk);
        chk("R10", "no strobe freq0", freq0_word, prev);
        chk("R10", "no strobe flags", {18'b0, dut_flags()}, 28'h085);

        // Reset drops pending
        cur_tag = "R11";
        wr(16'h2000);
        wr(16'h4000 | 16'h0101);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "mid reset freq0", freq0_word, 28'h0);
        chk("R11", "mid reset flags", {18'b0, dut_flags()}, 28'h0);
        wr(16'h2000);
        wr(16'h4000 | 16'h0202);
        chk("R11", "after reset first write", freq0_word, 28'h0);
        wr(16'h4000 | 16'h0303);
        chk("R11", "after reset full load", freq0_word, {14'h0303, 14'h0202});

        // Pseudo-random burst against the model
        cur_tag = "R1";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'b000) @(negedge clk);
            else wr(lfsr ^ {2'b00, lfsr[7:0], 6'b0});
        end
        @(negedge clk);
        finish_run();
    end
endmodule